// File: doc/BRIEF.md
# Per-VF Memory Aperture Decoder

This block examines the address of an inbound memory request and decides whether it lands inside the shared memory window that one virtual-function BAR reserves for all virtual functions. That window is cut into equal, power-of-two sized slices, one for each active virtual function, and the slices are laid out back to back from the window base. When an address lands in a live slice, the block reports the 1-based number of the owning function and the byte offset inside its slice. A queue selector further down the path uses those two values to route the request.

The window base, the slice size (given as a log2 value), the live function count, the function-enable control and the collective memory-decode enable are static configuration inputs. Each request is classified into one of four result kinds: idle (no request), gated miss, out-of-range miss, and hit. The kind and its associated values are registered, so every result appears exactly one clock after the request.

The slice number is found by shifting the address distance from the base right by the log2 slice size. The offset is the low log2-size bits of that distance. No multiply or divide is performed.

Top module: `vf_aperture_decoder`

## Requirements
- R1: While reset is held and after it is released with no request, out_valid, out_hit, out_vf and out_offset are all 0.
- R2: out_valid is 1 in the cycle after a cycle with req_valid 1, and 0 in the cycle after a cycle with req_valid 0.
- R3: On a hit, out_vf equals ((req_addr - win_base) >> slice_log2) + 1, and it always lies in the range 1 to vf_count.
- R4: On a hit, out_offset equals the low slice_log2 bits of (req_addr - win_base), with all higher bits 0.
- R5: An address below win_base gives out_hit 0.
- R6: An address at or above win_base + vf_count × 2^slice_log2 gives out_hit 0, even when it lies inside the enclosing power-of-two aligned window.
- R7: When vf_count is 0, no address gives a hit.
- R8: When vf_mem_en is 0, no address gives a hit, whatever the other inputs are.
- R9: When vfs_on is 0, no address gives a hit.
- R10: Whenever out_hit is 0, out_vf and out_offset are 0.
- R11: out_hit is 1 only in a cycle where out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request address is present this cycle |
| req_addr | input | ADDR_W | Request byte address |
| win_base | input | ADDR_W | Base of the shared VF window, aligned to its total size |
| slice_log2 | input | LOG2_W | log2 of the per-function slice size in bytes |
| vf_count | input | CNT_W | Number of live virtual functions |
| vfs_on | input | 1 | Virtual functions exist |
| vf_mem_en | input | 1 | Collective memory-decode enable for virtual functions |
| out_valid | output | 1 | A result is present |
| out_hit | output | 1 | The request hit a live slice |
| out_vf | output | CNT_W | 1-based function number on a hit, else 0 |
| out_offset | output | ADDR_W | Byte offset inside the slice on a hit, else 0 |

## Verification
The bench probes the edges of the live range. It checks the first byte and last byte of the first and last slices, the first byte past the final live slice, and the unused slices that still sit inside the aligned window. A decoder that compares against the power-of-two window rather than vf_count would hit in that gap, and an off-by-one on the slice number would misreport the function or pass the boundary. Addresses just below the base are checked for wraparound false hits. Each gating input is cleared on its own to show that none of them is ignored. The bench also checks that misses return zero in out_vf and out_offset rather than stale values, and that a cycle without a request produces no valid result.

// File: rtl/vfdec_pkg.sv
package vfdec_pkg;
    typedef enum logic [1:0] {
        RES_IDLE       = 2'd0,
        RES_MISS_GATED = 2'd1,
        RES_MISS_RANGE = 2'd2,
        RES_HIT        = 2'd3
    } dec_result_e;
endpackage

// File: rtl/vfdec_gate.sv
module vfdec_gate #(
    parameter int CNT_W = 16
) (
    input  logic             vfs_on,
    input  logic             vf_mem_en,
    input  logic [CNT_W-1:0] vf_count,
    output logic             open
);
    // Decode is possible only if functions exist, decode is on, and at least one is live.
    assign open = vfs_on && vf_mem_en && (vf_count != '0);
endmodule

// File: rtl/vfdec_slice_calc.sv
module vfdec_slice_calc #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LOG2_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [LOG2_W-1:0] log2sz,
    input  logic [CNT_W-1:0]  count,
    output logic              in_range,
    output logic [CNT_W-1:0]  slice_num,
    output logic [ADDR_W-1:0] offset
);
    localparam int PAD = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] idx;
    logic [ADDR_W-1:0] mask;
    logic              above;

    always_comb begin
        rel       = addr - base;
        idx       = rel >> log2sz;
        mask      = ~({ADDR_W{1'b1}} << log2sz);
        above     = (addr >= base);
        in_range  = above && (idx < {{PAD{1'b0}}, count});
        slice_num = idx[CNT_W-1:0] + CNT_W'(1);
        offset    = rel & mask;
    end
endmodule

// File: rtl/vf_aperture_decoder.sv
module vf_aperture_decoder
    import vfdec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LOG2_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [LOG2_W-1:0] slice_log2,
    input  logic [CNT_W-1:0]  vf_count,
    input  logic              vfs_on,
    input  logic              vf_mem_en,
    output logic              out_valid,
    output logic              out_hit,
    output logic [CNT_W-1:0]  out_vf,
    output logic [ADDR_W-1:0] out_offset
);
    logic              gate_open;
    logic              in_range;
    logic [CNT_W-1:0]  slice_num;
    logic [ADDR_W-1:0] slice_off;

    dec_result_e       kind_d;
    dec_result_e       kind_q;
    logic [CNT_W-1:0]  vf_d;
    logic [ADDR_W-1:0] off_d;

    vfdec_gate #(.CNT_W(CNT_W)) u_gate (
        .vfs_on    (vfs_on),
        .vf_mem_en (vf_mem_en),
        .vf_count  (vf_count),
        .open      (gate_open)
    );

    vfdec_slice_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOG2_W(LOG2_W)) u_calc (
        .addr      (req_addr),
        .base      (win_base),
        .log2sz    (slice_log2),
        .count     (vf_count),
        .in_range  (in_range),
        .slice_num (slice_num),
        .offset    (slice_off)
    );

    // Classification of the current request.
    always_comb begin
        if (!req_valid)      kind_d = RES_IDLE;
        else if (!gate_open) kind_d = RES_MISS_GATED;
        else if (!in_range)  kind_d = RES_MISS_RANGE;
        else                 kind_d = RES_HIT;
    end

    // Per-kind result values.
    always_comb begin
        vf_d  = '0;
        off_d = '0;
        unique case (kind_d)
            RES_IDLE:       begin vf_d = '0;        off_d = '0;        end
            RES_MISS_GATED: begin vf_d = '0;        off_d = '0;        end
            RES_MISS_RANGE: begin vf_d = '0;        off_d = '0;        end
            RES_HIT:        begin vf_d = slice_num; off_d = slice_off; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q     <= RES_IDLE;
            out_vf     <= '0;
            out_offset <= '0;
        end else begin
            kind_q     <= kind_d;
            out_vf     <= vf_d;
            out_offset <= off_d;
        end
    end

    assign out_valid = (kind_q != RES_IDLE);
    assign out_hit   = (kind_q == RES_HIT);

    p_latency_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    p_latency_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    p_vf_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (out_vf != '0) && (out_vf <= $past(vf_count)));
    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vf_count == '0) |=> !out_hit);
    p_mem_en_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vf_mem_en |=> !out_hit);
    p_vfs_on_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vfs_on |=> !out_hit);
    p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hit |-> (out_vf == '0) && (out_offset == '0));
    p_hit_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> out_valid);
endmodule

// File: tb/vf_aperture_decoder_bench.sv
module vf_aperture_decoder_bench;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int LOG2_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ADDR_W-1:0] win_base = '0;
    logic [LOG2_W-1:0] slice_log2 = '0;
    logic [CNT_W-1:0]  vf_count = '0;
    logic              vfs_on = 1'b0;
    logic              vf_mem_en = 1'b0;
    logic              out_valid;
    logic              out_hit;
    logic [CNT_W-1:0]  out_vf;
    logic [ADDR_W-1:0] out_offset;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vf_aperture_decoder #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOG2_W(LOG2_W)) u_vf_aperture_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .win_base(win_base), .slice_log2(slice_log2), .vf_count(vf_count),
        .vfs_on(vfs_on), .vf_mem_en(vf_mem_en), .out_valid(out_valid),
        .out_hit(out_hit), .out_vf(out_vf), .out_offset(out_offset)
    );

    task automatic check(input string req, input logic v, input logic h,
                         input logic [CNT_W-1:0] vf, input logic [ADDR_W-1:0] off);
        compared++;
        if (out_valid !== v || out_hit !== h || out_vf !== vf || out_offset !== off) begin
            mismatched++;
            $display("FAIL %s: got valid=%0b hit=%0b vf=%0d off=%h, expected valid=%0b hit=%0b vf=%0d off=%h",
                     req, out_valid, out_hit, out_vf, out_offset, v, h, vf, off);
        end
    endtask

    // Model built from the slice layout: slice n spans base+(n-1)*size .. base+n*size-1.
    task automatic probe(input string req, input logic [ADDR_W-1:0] a);
        longint size, lo, hi;
        logic exp_hit;
        logic [CNT_W-1:0] exp_vf;
        logic [ADDR_W-1:0] exp_off;
        size = longint'(1) << slice_log2;
        lo = longint'(win_base);
        hi = lo + size * longint'(vf_count);
        exp_hit = vfs_on && vf_mem_en && (longint'(a) >= lo) && (longint'(a) < hi);
        exp_vf  = exp_hit ? CNT_W'((longint'(a) - lo) / size + 1) : '0;
        exp_off = exp_hit ? ADDR_W'((longint'(a) - lo) % size) : '0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        check(req, 1'b1, exp_hit, exp_vf, exp_off);
        req_valid = 1'b0;
    endtask

    task automatic configure(input logic [ADDR_W-1:0] b, input int lg, input int n,
                             input logic en, input logic mse);
        @(negedge clk);
        win_base = b; slice_log2 = LOG2_W'(lg); vf_count = CNT_W'(n);
        vfs_on = en; vf_mem_en = mse;
    endtask

    task automatic test_reset;
        @(negedge clk);
        check("R1 in reset", 1'b0, 1'b0, '0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, 1'b0, '0, '0);
    endtask

    task automatic test_hits;
        configure(32'h8000_0000, 12, 5, 1'b1, 1'b1);
        probe("R3 first byte of slice 1", 32'h8000_0000);
        probe("R4 last byte of slice 1", 32'h8000_0FFF);
        probe("R3 slice 2 start", 32'h8000_1000);
        probe("R4 mid slice 3", 32'h8000_2ABC);
        probe("R3 last byte of slice 5", 32'h8000_4FFF);
        check("R3 slice 5 explicit", 1'b1, 1'b1, 16'd5, 32'h0000_0FFF);
    endtask

    task automatic test_below;
        configure(32'h8000_0000, 12, 5, 1'b1, 1'b1);
        probe("R5 one below base", 32'h7FFF_FFFF);
        check("R5 explicit miss", 1'b1, 1'b0, '0, '0);
        probe("R5 address zero", 32'h0000_0000);
    endtask

    task automatic test_beyond;
        configure(32'h8000_0000, 12, 5, 1'b1, 1'b1);
        probe("R6 first byte past slice 5", 32'h8000_5000);
        check("R6 explicit miss, R10 zero fields", 1'b1, 1'b0, '0, '0);
        probe("R6 unused slice 8 in aligned window", 32'h8000_7FFF);
    endtask

    task automatic test_zero_count;
        configure(32'h8000_0000, 12, 0, 1'b1, 1'b1);
        probe("R7 count zero at base", 32'h8000_0000);
        check("R7 explicit miss", 1'b1, 1'b0, '0, '0);
    endtask

    task automatic test_mse_off;
        configure(32'h8000_0000, 12, 5, 1'b1, 1'b0);
        probe("R8 decode disabled", 32'h8000_1234);
        check("R8 explicit miss", 1'b1, 1'b0, '0, '0);
    endtask

    task automatic test_vfs_off;
        configure(32'h8000_0000, 12, 5, 1'b0, 1'b1);
        probe("R9 functions off", 32'h8000_1234);
        check("R9 explicit miss", 1'b1, 1'b0, '0, '0);
    endtask

    task automatic test_large_slices;
        configure(32'h0010_0000, 16, 3, 1'b1, 1'b1);
        probe("R3 big slice 2", 32'h0011_0010);
        check("R4 big slice 2 offset", 1'b1, 1'b1, 16'd2, 32'h0000_0010);
        probe("R6 big slice past count", 32'h0013_0000);
    endtask

    task automatic test_idle;
        configure(32'h8000_0000, 12, 5, 1'b1, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = 32'h8000_0000;
        @(negedge clk);
        check("R2 R11 no request, no result", 1'b0, 1'b0, '0, '0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        test_hits();
        test_below();
        test_beyond();
        test_zero_count();
        test_mse_off();
        test_vfs_off();
        test_large_slices();
        test_idle();
        finish_run();
    end
endmodule